// File: doc/BRIEF.md
# Time-Multiplexed Digital Neuron

This block is one digital neuron that listens to a shared activation bus. The bus is time-multiplexed: on each bus cycle a single source neuron places its signed output value on the bus, along with a 6-bit source index and a valid strobe. The neuron uses the index to fetch the matching signed 8-bit synaptic weight from a small local weight store. It multiplies that weight by the bus value in one shared multiplier and adds the product to a 24-bit accumulator. The same multiplier serves every connection, one connection per bus cycle.

An evaluation frame opens with a start pulse and closes with an end pulse. When the frame closes, the neuron compares the final sum with a programmable signed threshold. The 9-bit result is then either the largest positive code or zero, and a one-cycle done strobe marks the update. A host loads the weights and the threshold through simple write ports.

A weight of zero cuts the matching connection. Zeroing every weight takes the neuron out of the network. A broadcast beat injects the bus value at unit weight, whatever index it carries.

Top module: `mux_neuron`

## Requirements
- R1: While reset is asserted and after it is released, `result` is 0, `done` is 0, the accumulator is 0 and the threshold is 0.
- R2: Each valid, non-broadcast beat adds `busVal` × weight[`busIdx`] to the sum. Both operands are signed two's complement (9-bit value, 8-bit weight). The sum is a 24-bit signed value, so 64 beats of extreme operands never overflow.
- R3: A cycle with `busValid` low leaves the sum unchanged, whatever values are on `busVal`, `busIdx` and `busBcast`.
- R4: `frameStart` discards the earlier sum. A valid beat in the same cycle becomes the first term of the new frame.
- R5: A valid beat in the same cycle as `frameEnd` is included in the final sum. `result` becomes 255 (9'h0FF) when the signed sum is strictly greater than the threshold, and 0 otherwise, including when the two are equal.
- R6: `done` is high for exactly one cycle, two rising clock edges after `frameEnd` is sampled. `result` changes only in that cycle and holds at all other times.
- R7: A zero weight removes its source from the sum. With all 64 weights at zero, every frame sums to 0.
- R8: A valid beat with `busBcast` high adds `busVal` at unit weight and ignores the weight store at `busIdx`.
- R9: `hostWrEn` writes `hostWData` to weight[`hostAddr`]. A bus beat that reads the same index in the same cycle uses the old weight. Later beats use the new weight.
- R10: `thrWrEn` loads the signed 24-bit `thrWData` into the threshold. The new value is used by every frame end sampled after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Bus beat carries a value |
| busBcast | input | 1 | Beat is a broadcast, applied at unit weight |
| busIdx | input | 6 | Index of the source driving the bus |
| busVal | input | 9 | Signed value on the bus |
| frameStart | input | 1 | Open a frame and clear the sum |
| frameEnd | input | 1 | Close the frame and evaluate the threshold |
| hostWrEn | input | 1 | Weight write strobe |
| hostAddr | input | 6 | Weight index to write |
| hostWData | input | 8 | Signed weight value |
| thrWrEn | input | 1 | Threshold write strobe |
| thrWData | input | 24 | Signed threshold value |
| result | output | 9 | Thresholded neuron output |
| done | output | 1 | One-cycle strobe marking a result update |

## Verification
Full 64-source frames are run with several arithmetic weight and value patterns, with all-negative extremes, and with mixed-sign extremes. Each frame is evaluated once with the threshold one below the computed sum and once with the threshold equal to it. The flip between 255 and 0 therefore pins the exact sum, and it also catches an off-by-one in the compare. Odd patterns interleave idle beats that carry junk values, which separates correct valid gating from a design that accumulates everything. Separate short frames cover the remaining cases:
- stray beats before a start pulse
- a zeroed weight and a fully zeroed store
- a broadcast beat aimed at a zero weight
- a weight write that collides with a read of the same index

Each of these can only pass if the design honours that ordering.

// File: rtl/mux_neuron_pkg.sv
package mux_neuron_pkg;
  // strobes from control to datapath, aligned with the accumulate stage
  typedef struct packed {
    logic clrAcc;      // drop the previous sum
    logic addTerm;     // add this stage's term
    logic unitWeight;  // broadcast beat: skip the multiplier
    logic evalEnd;     // evaluate threshold and raise done
  } mac_strobe_t;
endpackage

// File: rtl/neuron_wmem.sv
module neuron_wmem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] store [DEPTH];

  // synchronous read; a same-edge write is seen only by later reads
  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    rdData <= store[rdAddr];
  end
endmodule

// File: rtl/neuron_ctrl.sv
module neuron_ctrl
  import mux_neuron_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busBcast,
  input  logic        frameStart,
  input  logic        frameEnd,
  output mac_strobe_t strobe
);
  logic validQ, bcastQ, startQ, endQ;

  // one register stage, matching the weight-store read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      bcastQ <= 1'b0;
      startQ <= 1'b0;
      endQ   <= 1'b0;
    end else begin
      validQ <= busValid;
      bcastQ <= busBcast & busValid;
      startQ <= frameStart;
      endQ   <= frameEnd;
    end
  end

  always_comb begin
    strobe.clrAcc     = startQ;
    strobe.addTerm    = validQ;
    strobe.unitWeight = bcastQ;
    strobe.evalEnd    = endQ;
  end
endmodule

// File: rtl/neuron_datapath.sv
module neuron_datapath
  import mux_neuron_pkg::*;
#(
  parameter int BUS_W = 9,
  parameter int WGT_W = 8,
  parameter int ACC_W = 24,
  localparam int PROD_W = BUS_W + WGT_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [BUS_W-1:0]         busVal,
  input  logic [WGT_W-1:0]         weightRd,
  input  mac_strobe_t              strobe,
  input  logic                     thrWrEn,
  input  logic [ACC_W-1:0]         thrWData,
  output logic signed [ACC_W-1:0]  accSum,
  output logic [BUS_W-1:0]         result,
  output logic                     done
);
  localparam logic [BUS_W-1:0] RES_MAX = {1'b0, {(BUS_W-1){1'b1}}};

  logic signed [BUS_W-1:0]  valQ;
  logic signed [WGT_W-1:0]  weightS;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  term, base, nextSum, thr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) valQ <= '0;
    else       valQ <= busVal;
  end

  assign weightS = weightRd;

  // one shared multiplier; broadcast beats bypass it at unit weight
  always_comb begin
    prod    = valQ * weightS;
    term    = strobe.unitWeight ? ACC_W'(valQ) : ACC_W'(prod);
    base    = strobe.clrAcc ? '0 : accSum;
    nextSum = strobe.addTerm ? base + term : base;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum <= '0;
      thr    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      accSum <= nextSum;
      if (thrWrEn) thr <= thrWData;
      done <= strobe.evalEnd;
      if (strobe.evalEnd) result <= (nextSum > thr) ? RES_MAX : '0;
    end
  end
endmodule

// File: rtl/mux_neuron.sv
module mux_neuron
  import mux_neuron_pkg::*;
#(
  parameter int BUS_W = 9,
  parameter int WGT_W = 8,
  parameter int SRC_N = 64,
  parameter int ACC_W = 24,
  localparam int IDX_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busBcast,
  input  logic [IDX_W-1:0] busIdx,
  input  logic [BUS_W-1:0] busVal,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             hostWrEn,
  input  logic [IDX_W-1:0] hostAddr,
  input  logic [WGT_W-1:0] hostWData,
  input  logic             thrWrEn,
  input  logic [ACC_W-1:0] thrWData,
  output logic [BUS_W-1:0] result,
  output logic             done
);
  mac_strobe_t             strobe;
  logic [WGT_W-1:0]        weightRd;
  logic signed [ACC_W-1:0] accSum;

  neuron_wmem #(.DEPTH(SRC_N), .WIDTH(WGT_W)) u_wmem (
    .clk(clk), .wrEn(hostWrEn), .wrAddr(hostAddr), .wrData(hostWData),
    .rdAddr(busIdx), .rdData(weightRd)
  );

  neuron_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busBcast(busBcast),
    .frameStart(frameStart), .frameEnd(frameEnd), .strobe(strobe)
  );

  neuron_datapath #(.BUS_W(BUS_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .busVal(busVal), .weightRd(weightRd),
    .strobe(strobe), .thrWrEn(thrWrEn), .thrWData(thrWData),
    .accSum(accSum), .result(result), .done(done)
  );
endmodule

// File: rtl/mux_neuron_chk.sv
module mux_neuron_chk #(
  parameter int BUS_W = 9,
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             frameStart,
  input logic             frameEnd,
  input logic [BUS_W-1:0] result,
  input logic             done,
  input logic [ACC_W-1:0] accSum
);
  localparam logic [BUS_W-1:0] RES_MAX = {1'b0, {(BUS_W-1){1'b1}}};
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R6
  done_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (done == $past(frameEnd, 2)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst >= 2'd1) && !done) |-> $stable(result));

  // R5
  result_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (result == '0) || (result == RES_MAX));

  // R3
  idle_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst >= 2'd2) && !$past(busValid, 2) && !$past(frameStart, 2))
      |-> $stable(accSum));
endmodule

bind mux_neuron mux_neuron_chk #(.BUS_W(BUS_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .frameStart(frameStart),
  .frameEnd(frameEnd), .result(result), .done(done), .accSum(accSum)
);

// File: tb/sim_mux_neuron.sv
module sim_mux_neuron;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 0, busBcast = 0, frameStart = 0, frameEnd = 0;
  logic [5:0] busIdx = '0;
  logic [8:0] busVal = '0;
  logic hostWrEn = 0, thrWrEn = 0;
  logic [5:0] hostAddr = '0;
  logic [7:0] hostWData = '0;
  logic [23:0] thrWData = '0;
  logic [8:0] result;
  logic done;

  int errors = 0, checks = 0;
  int wm [64];
  bit bV [128], bB [128];
  int bI [128], bX [128];

  always #10 clk = ~clk;

  mux_neuron u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busBcast(busBcast),
    .busIdx(busIdx), .busVal(busVal), .frameStart(frameStart),
    .frameEnd(frameEnd), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWData(hostWData), .thrWrEn(thrWrEn), .thrWData(thrWData),
    .result(result), .done(done)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrW(int a, int w);
    @(negedge clk);
    hostWrEn = 1; hostAddr = 6'(a); hostWData = 8'(w); wm[a] = w;
    @(negedge clk);
    hostWrEn = 0;
  endtask

  task automatic wrThr(int t);
    @(negedge clk);
    thrWrEn = 1; thrWData = 24'(t);
    @(negedge clk);
    thrWrEn = 0;
  endtask

  function automatic int expSum(int n);
    int s = 0;
    for (int k = 0; k < n; k++)
      if (bV[k]) s += bB[k] ? bX[k] : bX[k] * wm[bI[k]];
    return s;
  endfunction

  // drive n beats, start on first, end on last; check result and done
  task automatic frame(int n, int thr, int expRes, string req);
    wrThr(thr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      busValid = bV[k]; busBcast = bB[k];
      busIdx = 6'(bI[k]); busVal = 9'(bX[k]);
      frameStart = (k == 0); frameEnd = (k == n - 1);
    end
    @(negedge clk);
    busValid = 0; busBcast = 0; frameStart = 0; frameEnd = 0; busVal = 9'h1AB;
    @(negedge clk);
    chk(done == 1'b1, "R6 done", int'(done), 1);
    chk(int'(result) == expRes, req, int'(result), expRes);
    @(negedge clk);
    chk(done == 1'b0, "R6 done pulse", int'(done), 0);
    chk(int'(result) == expRes, "R6 hold", int'(result), expRes);
  endtask

  task automatic bracket(int n, string req);
    int s = expSum(n);
    frame(n, s - 1, 255, req);
    frame(n, s, 0, req);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result == 0, "R1 result", int'(result), 0);
    chk(done == 0, "R1 done", int'(done), 0);
    rstN = 1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) wrW(i, 0);
    // R1: sum and threshold both 0 after reset, equal -> 0
    bV[0] = 0; bB[0] = 0; bI[0] = 0; bX[0] = 0;
    frame(1, 0, 0, "R1 thr/sum zero");

    // R2, R3, R5, R10: arithmetic pattern sweep, idle beats on odd seeds
    for (int seed = 0; seed < 4; seed++) begin
      int n = 0;
      for (int i = 0; i < 64; i++) wrW(i, ((i * (37 + 2 * seed) + seed * 11) % 256) - 128);
      for (int i = 0; i < 64; i++) begin
        if (seed % 2 == 1) begin
          bV[n] = 0; bB[n] = 1; bI[n] = 63 - i; bX[n] = 200 - i; n++;
        end
        bV[n] = 1; bB[n] = 0; bI[n] = (i * 7 + seed) % 64;
        bX[n] = ((i * 53 + seed * 29 + 11) % 512) - 256; n++;
      end
      bracket(n, (seed % 2 == 1) ? "R3 idle beats" : "R2 weighted sum");
    end

    // R2: extremes, no overflow in 24 bits
    for (int i = 0; i < 64; i++) wrW(i, -128);
    for (int i = 0; i < 64; i++) begin bV[i] = 1; bB[i] = 0; bI[i] = i; bX[i] = -256; end
    bracket(64, "R2 max positive");
    for (int i = 0; i < 64; i++) bX[i] = 255;
    bracket(64, "R2 max negative");

    // R4: stray beats before start must not count
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      busValid = 1; busIdx = 6'(k); busVal = 9'(100);
    end
    @(negedge clk); busValid = 0;
    bV[0] = 1; bI[0] = 3; bX[0] = 2; bB[0] = 0;
    bV[1] = 1; bI[1] = 4; bX[1] = -1; bB[1] = 0;
    bracket(2, "R4 start clears");

    // R7: zero weight disconnects
    wrW(5, 0); wrW(6, 10);
    bV[0] = 1; bI[0] = 5; bX[0] = 255; bV[1] = 1; bI[1] = 6; bX[1] = 3;
    bracket(2, "R7 zero weight");
    for (int i = 0; i < 64; i++) wrW(i, 0);
    for (int i = 0; i < 64; i++) begin bV[i] = 1; bB[i] = 0; bI[i] = i; bX[i] = 200 - 7 * i; end
    frame(64, -1, 255, "R7 all zero");
    frame(64, 0, 0, "R7 all zero");

    // R8: broadcast at unit weight even on a zero weight
    bV[0] = 1; bB[0] = 1; bI[0] = 9; bX[0] = -77;
    bV[1] = 1; bB[1] = 1; bI[1] = 10; bX[1] = 30;
    frame(2, -48, 255, "R8 broadcast");
    frame(2, -47, 0, "R8 broadcast");

    // R9: write collides with read of same index
    wrW(7, 3);
    wrThr(299);
    @(negedge clk);
    busValid = 1; busBcast = 0; busIdx = 7; busVal = 9'(100);
    frameStart = 1; frameEnd = 1;
    hostWrEn = 1; hostAddr = 7; hostWData = 8'(-2); wm[7] = -2;
    @(negedge clk);
    busValid = 0; frameStart = 0; frameEnd = 0; hostWrEn = 0;
    @(negedge clk);
    chk(result == 9'd255, "R9 old weight", int'(result), 255);
    bV[0] = 1; bB[0] = 0; bI[0] = 7; bX[0] = 100;
    frame(1, 299, 0, "R9 new weight");
    frame(1, -201, 255, "R9 new weight");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule